// File: doc/BRIEF.md
# Multi-Channel Timer and PWM Bank

This block is a bank of independent up-counting timers. Each timer has its own period limit, its own duty threshold and its own pulse-width output. A host reaches it through a small memory-mapped port. That port has an address, 32-bit write data, four byte-lane enables, a write strobe and a combinational read-data path. Three count sources arrive as one-cycle tick enables: a peripheral tick, a real-time tick and an external tick. Each channel selects any of the three sources and divides the selected ticks by a power of four before its counter advances.

Four shared 32-bit words control the whole bank:
- a run-permission word;
- a freeze word;
- an event word;
- an event-mask word.

Each word has a plain write address, a bit-set address and a bit-clear address, so firmware can change one channel's bit without a read-modify-write. A channel raises two events, one when its counter reaches the duty threshold and one when it reaches the period limit. Unmasked events combine into a single interrupt line.

Each pulse output is active from the start of a period until the duty threshold and inactive from there to the end of the period. Its polarity can be inverted. When the output is switched off, it can either go idle at once or be allowed to finish the current period.

Top module: `tmr_pwm_bank`

## Requirements
- R1: After reset, the run-permission, freeze, event and counter values read 0, and every implemented event-mask bit reads 1. irq_o and all pulse outputs are low.
- R2: Shared words have these addresses, given as plain write / bit-set / bit-clear:
  - run-permission: 0x00 / 0x04 / 0x08;
  - freeze: 0x0C / 0x1C / 0x2C;
  - event: 0x10 / 0x14 / 0x18;
  - mask: 0x20 / 0x24 / 0x28.

  A 1 in an enabled byte lane sets or clears only that bit, and 0 bits leave the word unchanged. Bits with no channel behind them always read 0.
- R3: Channel n decodes at 0x30 + 0x10·n:
  - period limit at +0x0;
  - duty threshold at +0x4;
  - counter at +0x8, readable and writable;
  - control at +0xC.

  These registers are 16 bits wide, and writes honour byte lanes 0 and 1. Reading a plain address returns the register. Reading a set or clear address returns 0.
- R4: A counter advances only while its run-permission bit is 1 and its freeze bit is 0, and only on a tick from a source it selects. Control bit 0 selects the peripheral tick, bit 1 the real-time tick and bit 2 the external tick.
- R5: Control bits [5:3] hold a code c. The counter advances once per 4^c selected ticks. Codes above 5 behave as 5, which divides by 1024.
- R6: On each advance the counter increments. If the counter already equals the period limit, it returns to 0 instead.
- R7: An advance that brings the counter to the duty threshold sets event bit 16+n. An advance that brings it to the period limit sets event bit n.
- R8: An event raised by a channel in the same cycle as a bus clear of that bit leaves the bit set.
- R9: While control bit 7 is 1, the pulse output is active while counter < duty threshold and inactive otherwise. Control bit 8 = 1 makes the active level low.
- R10: If control bit 7 is cleared with control bit 9 = 1, the output goes idle on the cycle after the write. If bit 9 = 0, the output keeps following R9 until the counter next wraps to 0, then goes idle.
- R11: irq_o is high exactly when some event bit is 1 while its mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | AW | Byte address (AW = clog2(0x30 + 0x10·NCH)) |
| bus_wdata_i | input | 32 | Write data |
| bus_be_i | input | 4 | Byte-lane enables |
| bus_we_i | input | 1 | Write strobe, one write per cycle |
| bus_rdata_o | output | 32 | Combinational read data for bus_addr_i |
| tick_per_i | input | 1 | Peripheral tick enable |
| tick_rtc_i | input | 1 | Real-time tick enable |
| tick_ext_i | input | 1 | External tick enable |
| pwm_o | output | NCH | Pulse outputs, bit n for channel n |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the bank with NCH = 4, CNT_W = 16 and MAX_CODE = 5. With four channels, the highest channel window and the unimplemented run, mask and event bits are reachable in a short run, so the zero-readback rule of R2 can be checked. A full 16-bit period together with the top prescale code, and an out-of-range code that falls back to it, puts the 1024-tick boundary of R5 within about a thousand ticks. A short three-count period on a third channel exercises the R9 pulse levels, both R10 shutdown styles and the set-versus-clear race of R8 with cycle-exact expectations.

// File: rtl/tpb_pkg.sv
package tpb_pkg;

   // shared word addresses
   localparam int OFS_EN       = 'h00;
   localparam int OFS_EN_SET   = 'h04;
   localparam int OFS_EN_CLR   = 'h08;
   localparam int OFS_STOP     = 'h0C;
   localparam int OFS_FLAG     = 'h10;
   localparam int OFS_FLAG_SET = 'h14;
   localparam int OFS_FLAG_CLR = 'h18;
   localparam int OFS_STOP_SET = 'h1C;
   localparam int OFS_MASK     = 'h20;
   localparam int OFS_MASK_SET = 'h24;
   localparam int OFS_MASK_CLR = 'h28;
   localparam int OFS_STOP_CLR = 'h2C;

   // per-channel window
   localparam int CH_BASE   = 'h30;
   localparam int CH_STRIDE = 'h10;
   localparam int RG_FULL   = 0;
   localparam int RG_HALF   = 1;
   localparam int RG_CNT    = 2;
   localparam int RG_CTRL   = 3;
   localparam int RG_NUM    = 4;

   // control bit positions
   localparam int CB_PRE_LO  = 3;
   localparam int CB_PWM_EN  = 7;
   localparam int CB_POL_LOW = 8;
   localparam int CB_ABRUPT  = 9;

   localparam int HALF_SHIFT = 16;

   typedef enum logic [1:0] {OP_NONE, OP_WRITE, OP_SET, OP_CLR} reg_op_e;

   function automatic logic [31:0] lane_mask(input logic [3:0] be);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
      return m;
   endfunction

   function automatic reg_op_e pick_op(input logic we, input int a,
                                       input int a_wr, input int a_set,
                                       input int a_clr);
      if (!we)            return OP_NONE;
      else if (a == a_wr) return OP_WRITE;
      else if (a == a_set) return OP_SET;
      else if (a == a_clr) return OP_CLR;
      return OP_NONE;
   endfunction

   function automatic logic [31:0] apply_op(input logic [31:0] cur,
                                            input logic [31:0] wd,
                                            input logic [3:0] be,
                                            input reg_op_e op);
      logic [31:0] m;
      m = lane_mask(be);
      case (op)
         OP_WRITE: return (cur & ~m) | (wd & m);
         OP_SET:   return cur | (wd & m);
         OP_CLR:   return cur & ~(wd & m);
         default:  return cur;
      endcase
   endfunction

endpackage

// File: rtl/tpb_presc.sv
module tpb_presc #(
   parameter int MAX_CODE = 5
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       clr_i,
   input  logic       adv_i,
   input  logic [2:0] code_i,
   output logic       step_o
);
   localparam int PW = 2 * MAX_CODE;

   if (MAX_CODE < 1 || MAX_CODE > 7) begin : g_bad_code
      $error("tpb_presc: MAX_CODE must lie in 1..7");
   end

   logic [PW-1:0] pre_q;
   logic [PW-1:0] sel_mask;
   logic [2:0]    eff_code;

   always_comb begin
      eff_code = (int'(code_i) > MAX_CODE) ? 3'(MAX_CODE) : code_i;
      sel_mask = PW'((32'd1 << (32'd2 * 32'(eff_code))) - 32'd1);
   end

   assign step_o = adv_i && ((pre_q & sel_mask) == sel_mask);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      pre_q <= '0;
      else if (clr_i)   pre_q <= '0;
      else if (adv_i)   pre_q <= pre_q + 1'b1;
   end

   // R5: a divisor of 4 or more never yields two steps in a row
   p_presc_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_o && code_i != 3'd0) |=> (code_i == 3'd0 || !step_o));

endmodule

// File: rtl/tpb_chan.sv
module tpb_chan import tpb_pkg::*; #(
   parameter int CNT_W    = 16,
   parameter int MAX_CODE = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              stop_i,
   input  logic [2:0]        src_tick_i,
   input  logic [RG_NUM-1:0] wr_i,
   input  logic [15:0]       wdata_i,
   input  logic [1:0]        be_i,
   output logic [15:0]       full_o,
   output logic [15:0]       half_o,
   output logic [15:0]       cnt_o,
   output logic [15:0]       ctrl_o,
   output logic              hit_full_o,
   output logic              hit_half_o,
   output logic              pwm_o
);
   logic [CNT_W-1:0] full_q, half_q, cnt_q, cnt_inc;
   logic [15:0]      ctrl_q;
   logic             hold_q;
   logic             run, adv, step, wrap, tick_ok, drive_on, active;
   logic [15:0]      lane16;

   // widen to the bus width; the variant depends on CNT_W
   if (CNT_W == 16) begin : g_wide
      assign full_o = full_q;
      assign half_o = half_q;
      assign cnt_o  = cnt_q;
   end else begin : g_narrow
      assign full_o = {{(16-CNT_W){1'b0}}, full_q};
      assign half_o = {{(16-CNT_W){1'b0}}, half_q};
      assign cnt_o  = {{(16-CNT_W){1'b0}}, cnt_q};
   end
   assign ctrl_o = ctrl_q;

   assign lane16 = {{8{be_i[1]}}, {8{be_i[0]}}};

   function automatic logic [15:0] merge(input logic [15:0] cur,
                                         input logic [15:0] wd,
                                         input logic [15:0] m);
      return (cur & ~m) | (wd & m);
   endfunction

   assign run = en_i && !stop_i;
   assign adv = run && |(ctrl_q[2:0] & src_tick_i);

   tpb_presc #(.MAX_CODE(MAX_CODE)) u_presc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (!en_i),
      .adv_i  (adv),
      .code_i (ctrl_q[CB_PRE_LO +: 3]),
      .step_o (step)
   );

   assign wrap       = (cnt_q == full_q);
   assign cnt_inc    = wrap ? '0 : cnt_q + 1'b1;
   assign tick_ok    = step && !wr_i[RG_CNT];
   assign hit_full_o = tick_ok && (cnt_inc == full_q);
   assign hit_half_o = tick_ok && (cnt_inc == half_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         full_q <= '0;
         half_q <= '0;
         cnt_q  <= '0;
         ctrl_q <= '0;
         hold_q <= 1'b0;
      end else begin
         if (wr_i[RG_FULL]) full_q <= CNT_W'(merge(full_o, wdata_i, lane16));
         if (wr_i[RG_HALF]) half_q <= CNT_W'(merge(half_o, wdata_i, lane16));
         if (wr_i[RG_CTRL]) ctrl_q <= merge(ctrl_q, wdata_i, lane16);
         if (wr_i[RG_CNT])  cnt_q  <= CNT_W'(merge(cnt_o, wdata_i, lane16));
         else if (tick_ok)  cnt_q  <= cnt_inc;
         if (ctrl_q[CB_PWM_EN])                      hold_q <= 1'b1;
         else if ((tick_ok && wrap) || ctrl_q[CB_ABRUPT]) hold_q <= 1'b0;
      end
   end

   assign drive_on = ctrl_q[CB_PWM_EN] || (hold_q && !ctrl_q[CB_ABRUPT]);
   assign active   = (cnt_q < half_q);
   assign pwm_o    = ctrl_q[CB_POL_LOW] ^ (drive_on && active);

   // R4: a channel without run permission keeps its count
   p_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run && !wr_i[RG_CNT]) |=> $stable(cnt_q));

   // R6: a step taken at the period limit lands on zero
   p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step && wrap && !wr_i[RG_CNT]) |=> (cnt_q == '0));

   // R10: abrupt shutdown holds the idle level
   p_abrupt_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctrl_q[CB_PWM_EN] && ctrl_q[CB_ABRUPT]) |-> (pwm_o == ctrl_q[CB_POL_LOW]));

endmodule

// File: rtl/tpb_glob.sv
module tpb_glob import tpb_pkg::*; #(
   parameter int NCH = 8,
   parameter int AW  = 8
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           we_i,
   input  logic [AW-1:0]  addr_i,
   input  logic [31:0]    wdata_i,
   input  logic [3:0]     be_i,
   input  logic [NCH-1:0] hit_full_i,
   input  logic [NCH-1:0] hit_half_i,
   output logic [31:0]    en_o,
   output logic [31:0]    stop_o,
   output logic [31:0]    flag_o,
   output logic [31:0]    mask_o,
   output logic           irq_o
);
   localparam logic [31:0] CH_BITS   = 32'((64'd1 << NCH) - 64'd1);
   localparam logic [31:0] FLAG_BITS = CH_BITS | (CH_BITS << HALF_SHIFT);

   int          a_int;
   logic [31:0] hw_set, wbits;
   reg_op_e     op_en, op_stop, op_flag, op_mask;

   always_comb begin
      a_int   = int'(addr_i);
      op_en   = pick_op(we_i, a_int, OFS_EN,   OFS_EN_SET,   OFS_EN_CLR);
      op_stop = pick_op(we_i, a_int, OFS_STOP, OFS_STOP_SET, OFS_STOP_CLR);
      op_flag = pick_op(we_i, a_int, OFS_FLAG, OFS_FLAG_SET, OFS_FLAG_CLR);
      op_mask = pick_op(we_i, a_int, OFS_MASK, OFS_MASK_SET, OFS_MASK_CLR);
      wbits   = wdata_i & lane_mask(be_i);
      hw_set  = '0;
      hw_set[NCH-1:0]          = hit_full_i;
      hw_set[HALF_SHIFT +: NCH] = hit_half_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_o   <= '0;
         stop_o <= '0;
         flag_o <= '0;
         mask_o <= FLAG_BITS;
      end else begin
         en_o   <= apply_op(en_o,   wdata_i, be_i, op_en)   & CH_BITS;
         stop_o <= apply_op(stop_o, wdata_i, be_i, op_stop) & CH_BITS;
         flag_o <= (apply_op(flag_o, wdata_i, be_i, op_flag) | hw_set) & FLAG_BITS;
         mask_o <= apply_op(mask_o, wdata_i, be_i, op_mask) & FLAG_BITS;
      end
   end

   assign irq_o = |(flag_o & ~mask_o);

   // R7 and R8: a channel event always lands, whatever the bus does
   p_flag_latch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|hw_set) |=> ((flag_o & $past(hw_set)) == $past(hw_set)));

   // R2: bit-set address raises every written implemented bit
   p_en_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_en == OP_SET) |=> ((en_o & $past(wbits & CH_BITS)) == $past(wbits & CH_BITS)));

   // R2: bit-clear address drops every written bit
   p_mask_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_mask == OP_CLR) |=> ((mask_o & $past(wbits)) == 32'h0));

endmodule

// File: rtl/tmr_pwm_bank.sv
module tmr_pwm_bank import tpb_pkg::*; #(
   parameter  int NCH      = 8,
   parameter  int CNT_W    = 16,
   parameter  int MAX_CODE = 5,
   localparam int AW       = $clog2(CH_BASE + CH_STRIDE * NCH)
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic [AW-1:0]  bus_addr_i,
   input  logic [31:0]    bus_wdata_i,
   input  logic [3:0]     bus_be_i,
   input  logic           bus_we_i,
   output logic [31:0]    bus_rdata_o,
   input  logic           tick_per_i,
   input  logic           tick_rtc_i,
   input  logic           tick_ext_i,
   output logic [NCH-1:0] pwm_o,
   output logic           irq_o
);
   if (NCH < 1 || NCH > 16) begin : g_bad_nch
      $error("tmr_pwm_bank: NCH must lie in 1..16");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cntw
      $error("tmr_pwm_bank: CNT_W must lie in 1..16");
   end

   logic [31:0]    en_w, stop_w, flag_w, mask_w;
   logic [NCH-1:0] hit_full_w, hit_half_w;
   logic [15:0]    full_w [NCH];
   logic [15:0]    half_w [NCH];
   logic [15:0]    cnt_w  [NCH];
   logic [15:0]    ctrl_w [NCH];
   logic [2:0]     src_w;

   assign src_w = {tick_ext_i, tick_rtc_i, tick_per_i};

   tpb_glob #(.NCH(NCH), .AW(AW)) u_glob (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (bus_we_i),
      .addr_i     (bus_addr_i),
      .wdata_i    (bus_wdata_i),
      .be_i       (bus_be_i),
      .hit_full_i (hit_full_w),
      .hit_half_i (hit_half_w),
      .en_o       (en_w),
      .stop_o     (stop_w),
      .flag_o     (flag_w),
      .mask_o     (mask_w),
      .irq_o      (irq_o)
   );

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      logic [RG_NUM-1:0] wr_sel;
      for (genvar k = 0; k < RG_NUM; k++) begin : g_dec
         assign wr_sel[k] = bus_we_i &&
                            (bus_addr_i == AW'(CH_BASE + CH_STRIDE * n + 4 * k));
      end
      tpb_chan #(.CNT_W(CNT_W), .MAX_CODE(MAX_CODE)) u_chan (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .en_i       (en_w[n]),
         .stop_i     (stop_w[n]),
         .src_tick_i (src_w),
         .wr_i       (wr_sel),
         .wdata_i    (bus_wdata_i[15:0]),
         .be_i       (bus_be_i[1:0]),
         .full_o     (full_w[n]),
         .half_o     (half_w[n]),
         .cnt_o      (cnt_w[n]),
         .ctrl_o     (ctrl_w[n]),
         .hit_full_o (hit_full_w[n]),
         .hit_half_o (hit_half_w[n]),
         .pwm_o      (pwm_o[n])
      );
   end

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i == AW'(OFS_EN))   bus_rdata_o = en_w;
      if (bus_addr_i == AW'(OFS_STOP)) bus_rdata_o = stop_w;
      if (bus_addr_i == AW'(OFS_FLAG)) bus_rdata_o = flag_w;
      if (bus_addr_i == AW'(OFS_MASK)) bus_rdata_o = mask_w;
      for (int n = 0; n < NCH; n++) begin
         if (bus_addr_i == AW'(CH_BASE + CH_STRIDE * n + 4 * RG_FULL))
            bus_rdata_o = {16'h0, full_w[n]};
         if (bus_addr_i == AW'(CH_BASE + CH_STRIDE * n + 4 * RG_HALF))
            bus_rdata_o = {16'h0, half_w[n]};
         if (bus_addr_i == AW'(CH_BASE + CH_STRIDE * n + 4 * RG_CNT))
            bus_rdata_o = {16'h0, cnt_w[n]};
         if (bus_addr_i == AW'(CH_BASE + CH_STRIDE * n + 4 * RG_CTRL))
            bus_rdata_o = {16'h0, ctrl_w[n]};
      end
   end

   // R11: the interrupt only rises after a channel event or a bus write
   p_irq_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o) |-> $past((|hit_full_w) || (|hit_half_w) || bus_we_i));

endmodule

// File: tb/tmr_pwm_bank_bench.sv
`timescale 1ns/1ps
module tmr_pwm_bank_bench;
   localparam int NCH = 4;
   localparam int AW  = $clog2(48 + 16 * NCH);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [AW-1:0]  addr = '0;
   logic [31:0]    wdata = '0;
   logic [3:0]     be = 4'hF;
   logic           we = 1'b0;
   logic [31:0]    rdata;
   logic           t_per = 1'b0, t_rtc = 1'b0, t_ext = 1'b0;
   logic [NCH-1:0] pwm;
   logic           irq;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   tmr_pwm_bank #(.NCH(NCH), .CNT_W(16), .MAX_CODE(5)) u_tmr_pwm_bank (
      .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
      .bus_be_i(be), .bus_we_i(we), .bus_rdata_o(rdata),
      .tick_per_i(t_per), .tick_rtc_i(t_rtc), .tick_ext_i(t_ext),
      .pwm_o(pwm), .irq_o(irq));

   // scoreboard
   typedef struct {
      int          kind;   // 0 read, 1 pulse pin, 2 interrupt
      int          idx;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sbq[$];
   event  chk_ev;

   initial forever begin
      @(chk_ev);
      #1;
      while (sbq.size() > 0) begin
         item_t       it;
         logic [31:0] act;
         it = sbq.pop_front();
         case (it.kind)
            0:       act = rdata;
            1:       act = {31'h0, pwm[it.idx]};
            default: act = {31'h0, irq};
         endcase
         n_chk++;
         if (act !== it.exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   task automatic push(input int kind, input int idx, input logic [31:0] e, input string tag);
      item_t it;
      it.kind = kind; it.idx = idx; it.exp = e; it.tag = tag;
      sbq.push_back(it);
      -> chk_ev;
      #2;
   endtask

   task automatic bus_wr(input int a, input logic [31:0] d, input logic [3:0] lanes = 4'hF);
      @(negedge clk);
      addr = AW'(a); wdata = d; be = lanes; we = 1'b1;
      @(negedge clk);
      we = 1'b0; be = 4'hF;
   endtask

   task automatic exp_rd(input int a, input logic [31:0] e, input string tag);
      @(negedge clk);
      addr = AW'(a);
      push(0, 0, e, tag);
   endtask

   task automatic exp_pwm(input int ch, input bit e, input string tag);
      push(1, ch, {31'h0, e}, tag);
   endtask

   task automatic exp_irq(input bit e, input string tag);
      push(2, 0, {31'h0, e}, tag);
   endtask

   task automatic pulse(input int src, input int n);
      @(negedge clk);
      if (src == 0) t_per = 1'b1; else if (src == 1) t_rtc = 1'b1; else t_ext = 1'b1;
      repeat (n) @(negedge clk);
      t_per = 1'b0; t_rtc = 1'b0; t_ext = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      exp_rd('h00, 32'h0, "R1 run word after reset");
      exp_rd('h0C, 32'h0, "R1 freeze word after reset");
      exp_rd('h10, 32'h0, "R1 event word after reset");
      exp_rd('h20, 32'h000F000F, "R1 mask word after reset");
      exp_rd('h38, 32'h0, "R1 counter after reset");
      exp_irq(1'b0, "R1 irq after reset");
      exp_pwm(0, 1'b0, "R1 pulse pin after reset");

      // R2 set / clear aliases
      bus_wr('h04, 32'h5);
      bus_wr('h08, 32'h1);
      exp_rd('h00, 32'h4, "R2 run word set then clear");
      exp_rd('h04, 32'h0, "R3 set alias reads zero");
      bus_wr('h00, 32'h0);
      bus_wr('h1C, 32'h3);
      bus_wr('h2C, 32'h1);
      exp_rd('h0C, 32'h2, "R2 freeze word set then clear");
      bus_wr('h2C, 32'hF);
      bus_wr('h28, 32'h1);
      exp_rd('h20, 32'h000F000E, "R2 mask clear one bit");
      bus_wr('h24, 32'hFFFFFFFF);
      exp_rd('h20, 32'h000F000F, "R2 unimplemented mask bits read zero");

      // R11 masking
      bus_wr('h14, 32'h00010000);
      exp_irq(1'b0, "R11 masked event");
      bus_wr('h28, 32'h00010000);
      exp_irq(1'b1, "R11 unmasked event");
      exp_rd('h10, 32'h00010000, "R2 event set alias");
      bus_wr('h18, 32'h00010000);
      exp_irq(1'b0, "R11 event cleared");
      bus_wr('h20, 32'h000F000F);

      // R3 byte lanes
      bus_wr('h40, 32'hABCD, 4'b0001);
      exp_rd('h40, 32'h000000CD, "R3 low lane write");
      bus_wr('h40, 32'h1234, 4'b0010);
      exp_rd('h40, 32'h000012CD, "R3 high lane write");

      // R4 R6 R7 counting on channel 0
      bus_wr('h30, 32'd5);
      bus_wr('h34, 32'd2);
      bus_wr('h3C, 32'h0001);
      bus_wr('h04, 32'h1);
      pulse(0, 3);
      exp_rd('h38, 32'd3, "R4 counter after three ticks");
      exp_rd('h10, 32'h00010000, "R7 duty event");
      pulse(0, 2);
      exp_rd('h38, 32'd5, "R6 counter at limit");
      exp_rd('h10, 32'h00010001, "R7 period event");
      pulse(0, 1);
      exp_rd('h38, 32'd0, "R6 wrap to zero");
      bus_wr('h1C, 32'h1);
      pulse(0, 3);
      exp_rd('h38, 32'd0, "R4 frozen channel holds");
      bus_wr('h2C, 32'h1);
      pulse(1, 2);
      exp_rd('h38, 32'd0, "R4 unselected source ignored");
      bus_wr('h38, 32'd4);
      exp_rd('h38, 32'd4, "R3 counter write");

      // R5 prescale on channel 1, real-time source
      bus_wr('h40, 32'hFFFF);
      bus_wr('h4C, 32'h000A);
      bus_wr('h04, 32'h2);
      pulse(1, 7);
      exp_rd('h48, 32'd1, "R5 divide by four, seven ticks");
      pulse(1, 1);
      exp_rd('h48, 32'd2, "R5 divide by four, eight ticks");
      bus_wr('h4C, 32'h0032);
      exp_rd('h4C, 32'h0032, "R3 control readback");
      pulse(1, 1015);
      exp_rd('h48, 32'd2, "R5 code six one tick short");
      pulse(1, 1);
      exp_rd('h48, 32'd3, "R5 code six divides by 1024");

      // R8 event raised during a bus clear
      @(negedge clk);
      addr = AW'('h18); wdata = 32'h1; be = 4'hF; we = 1'b1; t_per = 1'b1;
      @(negedge clk);
      we = 1'b0; t_per = 1'b0;
      exp_rd('h10, 32'h00010001, "R8 hardware set wins");
      bus_wr('h18, 32'hFFFFFFFF);
      exp_rd('h10, 32'h0, "R2 event clear all");

      // R9 pulse levels on channel 2
      bus_wr('h50, 32'd3);
      bus_wr('h54, 32'd2);
      bus_wr('h5C, 32'h0081);
      exp_pwm(2, 1'b1, "R9 active at count 0");
      bus_wr('h04, 32'h4);
      pulse(0, 1);
      exp_pwm(2, 1'b1, "R9 active at count 1");
      pulse(0, 1);
      exp_pwm(2, 1'b0, "R9 idle at duty");
      pulse(0, 1);
      exp_pwm(2, 1'b0, "R9 idle at limit");
      pulse(0, 1);
      exp_pwm(2, 1'b1, "R9 active after wrap");
      bus_wr('h5C, 32'h0181);
      exp_pwm(2, 1'b0, "R9 active-low level");
      pulse(0, 2);
      exp_pwm(2, 1'b1, "R9 active-low idle level");

      // R10 shutdown styles
      bus_wr('h58, 32'd0);
      bus_wr('h5C, 32'h0081);
      bus_wr('h5C, 32'h0001);
      exp_pwm(2, 1'b1, "R10 period finishes");
      pulse(0, 1);
      exp_pwm(2, 1'b1, "R10 still draining");
      pulse(0, 1);
      exp_pwm(2, 1'b0, "R10 duty reached while draining");
      pulse(0, 2);
      exp_pwm(2, 1'b0, "R10 idle after wrap");
      bus_wr('h5C, 32'h0081);
      exp_pwm(2, 1'b1, "R10 re-enabled");
      bus_wr('h5C, 32'h0201);
      exp_pwm(2, 1'b0, "R10 abrupt shutdown");

      // R11 period event of channel 2 unmasked
      bus_wr('h18, 32'hFFFFFFFF);
      bus_wr('h20, 32'h000F000B);
      exp_irq(1'b0, "R11 nothing pending");
      pulse(0, 3);
      exp_irq(1'b1, "R11 period event raises irq");
      bus_wr('h24, 32'h4);
      exp_irq(1'b0, "R11 mask set drops irq");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule